// File: doc/BRIEF.md
# Halted-Buffer Readout Port

This block gives a register-bus master a view into the staging buffer of a DMA engine. If the engine stops part-way through a job, data that was fetched from memory into the buffer may never have been written back out. This port lets software recover that data and work out how much of it is valid.

The port answers APB-style read transfers. It offers two things. The first is a pointer register that reports the buffer's read and write positions. The second is a read window, one word per buffer entry, onto the buffer storage.

Software can always read the pointer register. Window reads are served only while the engine reports idle and its enable bit is low. A window read at any other time returns zero and raises the slave-error response for that one transfer.

The storage is a small synchronous array that can map to block RAM. A simple fill and drain port stands in for the DMA data path, so the buffer can be loaded in tests.

Top module: `dmabuf_readout`

## Requirements
- R1: While `rst` is high, and in the cycle after it, both pointers are zero, `prdata` is zero and `pslverr` is low.
- R2: A read transfer whose `paddr[11]` is 1 addresses the window. It selects buffer entry `paddr[10:2]`; bits [1:0] are ignored. If the entry exists, `eng_idle` is 1 in the setup cycle and `eng_enable` is 0 in the setup cycle, the access phase returns that entry with `pslverr` low.
- R3: A window read whose setup cycle sees `eng_idle`=0 or `eng_enable`=1 returns zero with `pslverr` high in its access phase. `pslverr` is never high outside an access phase (`psel`=1 and `penable`=1).
- R4: A permitted window read whose entry index `paddr[10:2]` is DEPTH or more returns zero with `pslverr` low.
- R5: A read transfer with `paddr[11:2]` equal to word offset 0x40>>2 returns the read pointer in bits [7:0] and the write pointer in bits [23:16]. All other bits are zero. This read never errors, whatever the engine state. The valid count is (write − read) mod DEPTH.
- R6: A cycle with `fill_we` high stores `fill_data` at the write pointer and advances that pointer by one, modulo DEPTH. A cycle with `drain_re` high advances the read pointer by one, modulo DEPTH.
- R7: Window reads, whether permitted or not, leave both pointers unchanged.
- R8: Write transfers, and reads of any address other than the window and the pointer register, return zero with `pslverr` low and change no pointer or buffer entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write transfer (ignored apart from suppressing the read) |
| paddr | input | 12 | Byte offset within the block |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pslverr | output | 1 | Slave error, access phase only |
| eng_idle | input | 1 | Engine reports no activity |
| eng_enable | input | 1 | Engine enable control bit |
| fill_we | input | 1 | Test fill strobe: write at the write pointer |
| fill_data | input | DATA_W | Test fill data |
| drain_re | input | 1 | Test drain strobe: advance the read pointer |

## Verification
Every piece of internal state surfaces at the ports within one transfer. A wrong pointer shows up in the next pointer-register read. A misplaced or lost buffer word shows up as a wrong value in the next window read of that entry. A faulty permission gate appears in the same access phase as a missing or spurious `pslverr`, or as data leaking through while the error is raised. Random fills, drains and reads against a bench-side buffer model expose any divergence on the first read that touches the affected entry or pointer.

// File: rtl/dmabuf_pkg.sv
package dmabuf_pkg;
  typedef enum logic [1:0] {
    RG_NONE    = 2'd0,
    RG_PTR     = 2'd1,
    RG_WIN     = 2'd2,
    RG_WIN_OOR = 2'd3
  } region_e;

  localparam logic [11:0] PTR_OFS = 12'h040;
endpackage

// File: rtl/dmabuf_decode.sv
module dmabuf_decode
  import dmabuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [11:0]      paddr,
  output region_e          region,
  output logic [IDX_W-1:0] idx
);
  logic [8:0] word;

  always_comb begin
    word   = paddr[10:2];
    idx    = word[IDX_W-1:0];
    region = RG_NONE;
    if (paddr[11]) begin
      region = (32'(word) < DEPTH) ? RG_WIN : RG_WIN_OOR;
    end else if (paddr[11:2] == PTR_OFS[11:2]) begin
      region = RG_PTR;
    end
  end
endmodule

// File: rtl/dmabuf_ram.sv
module dmabuf_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dmabuf_ptrs.sv
module dmabuf_ptrs #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_wr,
  input  logic             adv_rd,
  output logic [IDX_W-1:0] wr_pos,
  output logic [IDX_W-1:0] rd_pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pos <= '0;
      rd_pos <= '0;
    end else begin
      if (adv_wr) wr_pos <= wr_pos + 1'b1;
      if (adv_rd) rd_pos <= rd_pos + 1'b1;
    end
  end
endmodule

// File: rtl/dmabuf_readout.sv
module dmabuf_readout
  import dmabuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  input  logic              eng_idle,
  input  logic              eng_enable,
  input  logic              fill_we,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              drain_re
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int WPTR_LSB = 16;

  region_e           dec_region;
  logic [IDX_W-1:0]  dec_idx;
  logic [IDX_W-1:0]  wr_ptr;
  logic [IDX_W-1:0]  rd_ptr;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] ptr_word;
  logic              rd_setup;
  logic              permit;
  logic              is_win;

  region_e           resp_region;
  logic              resp_deny;
  logic [DATA_W-1:0] resp_ptr;

  assign rd_setup = psel & ~penable & ~pwrite;
  assign permit   = eng_idle & ~eng_enable;
  assign is_win   = (dec_region == RG_WIN) || (dec_region == RG_WIN_OOR);

  dmabuf_decode #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .paddr  (paddr),
    .region (dec_region),
    .idx    (dec_idx)
  );

  dmabuf_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .adv_wr (fill_we),
    .adv_rd (drain_re),
    .wr_pos (wr_ptr),
    .rd_pos (rd_ptr)
  );

  dmabuf_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (fill_we),
    .waddr (wr_ptr),
    .wdata (fill_data),
    .re    (rd_setup && dec_region == RG_WIN && permit),
    .raddr (dec_idx),
    .rdata (ram_q)
  );

  always_comb begin
    ptr_word = '0;
    ptr_word[IDX_W-1:0] = rd_ptr;
    ptr_word[WPTR_LSB +: IDX_W] = wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_region <= RG_NONE;
      resp_deny   <= 1'b0;
      resp_ptr    <= '0;
    end else if (rd_setup) begin
      resp_region <= dec_region;
      resp_deny   <= is_win && !permit;
      resp_ptr    <= ptr_word;
    end else begin
      resp_region <= RG_NONE;
      resp_deny   <= 1'b0;
      resp_ptr    <= '0;
    end
  end

  always_comb begin
    prdata = '0;
    if (resp_region == RG_WIN && !resp_deny) prdata = ram_q;
    else if (resp_region == RG_PTR)          prdata = resp_ptr;
  end

  assign pslverr = resp_deny;
endmodule

// File: rtl/dmabuf_readout_chk.sv
module dmabuf_readout_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [11:0]       paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr,
  input logic              eng_idle,
  input logic              eng_enable,
  input logic              fill_we,
  input logic              drain_re,
  input logic [IDX_W-1:0]  wr_ptr,
  input logic [IDX_W-1:0]  rd_ptr
);
  logic setup_rd;
  assign setup_rd = psel && !penable && !pwrite;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (prdata == '0 && !pslverr && wr_ptr == '0 && rd_ptr == '0));

  assert_err_access_only_R3: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable) |-> !pslverr);

  assert_denied_window_R3: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && paddr[11] && (!eng_idle || eng_enable)) |=> (pslverr && prdata == '0));

  assert_oor_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && paddr[11] && 32'(paddr[10:2]) >= DEPTH && eng_idle && !eng_enable)
      |=> (prdata == '0 && !pslverr));

  assert_ptr_fields_R5: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && paddr[11:2] == 10'h010)
      |=> (!pslverr && prdata[IDX_W-1:0] == $past(rd_ptr) && prdata[16 +: IDX_W] == $past(wr_ptr)));

  assert_fill_step_R6: assert property (@(posedge clk) disable iff (rst)
    fill_we |=> wr_ptr == IDX_W'($past(wr_ptr) + 1'b1));

  assert_drain_step_R6: assert property (@(posedge clk) disable iff (rst)
    drain_re |=> rd_ptr == IDX_W'($past(rd_ptr) + 1'b1));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!fill_we && !drain_re) |=> ($stable(wr_ptr) && $stable(rd_ptr)));
endmodule

bind dmabuf_readout dmabuf_readout_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dmabuf_readout.sv
`timescale 1ns/1ps
module sim_dmabuf_readout;
  localparam int DEPTH = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]   paddr = '0;
  logic [DW-1:0] prdata;
  logic          pslverr;
  logic          eng_idle = 1'b1, eng_enable = 1'b0;
  logic          fill_we = 1'b0, drain_re = 1'b0;
  logic [DW-1:0] fill_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mdl_mem [DEPTH];
  int            mwp = 0;
  int            mrp = 0;

  always #2.5 clk = ~clk;

  dmabuf_readout #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .prdata(prdata), .pslverr(pslverr),
    .eng_idle(eng_idle), .eng_enable(eng_enable),
    .fill_we(fill_we), .fill_data(fill_data), .drain_re(drain_re)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_ptr();
    logic [DW-1:0] v = '0;
    v[7:0]   = 8'(mrp);
    v[23:16] = 8'(mwp);
    return v;
  endfunction

  function automatic void exp_read(input logic [11:0] a, input logic idle, input logic en,
                                   output logic [DW-1:0] d, output logic e);
    int w;
    d = '0;
    e = 1'b0;
    w = int'(a[10:2]);
    if (a[11]) begin
      if (!idle || en) e = 1'b1;
      else if (w < DEPTH) d = mdl_mem[w];
    end else if (a[11:2] == 10'h010) begin
      d = exp_ptr();
    end
  endfunction

  task automatic apb_read(input logic [11:0] a, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #0.5;
    d = prdata;
    e = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apb_write(input logic [11:0] a, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #0.5;
    d = prdata;
    e = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic do_fill(input logic [DW-1:0] v);
    @(negedge clk);
    fill_we = 1'b1; fill_data = v;
    @(negedge clk);
    fill_we = 1'b0;
    mdl_mem[mwp] = v;
    mwp = (mwp + 1) % DEPTH;
  endtask

  task automatic do_drain();
    @(negedge clk);
    drain_re = 1'b1;
    @(negedge clk);
    drain_re = 1'b0;
    mrp = (mrp + 1) % DEPTH;
  endtask

  task automatic read_and_check(input string req, input logic [11:0] a);
    logic [DW-1:0] d, ed;
    logic e, ee;
    exp_read(a, eng_idle, eng_enable, ed, ee);
    apb_read(a, d, e);
    chk(req, d, ed);
    chk(req, {31'd0, e}, {31'd0, ee});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, p0;
    logic e;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;

    repeat (3) @(negedge clk);
    chk("R1 prdata in reset", prdata, '0);
    chk("R1 pslverr in reset", {31'd0, pslverr}, '0);
    rst = 1'b0;
    read_and_check("R1 R5 pointers after reset", 12'h040);

    for (int i = 0; i < 5; i++) do_fill(32'hA500_0000 + i);
    read_and_check("R5 R6 pointers after fills", 12'h040);
    read_and_check("R2 window entry 0", 12'h800);
    read_and_check("R2 window entry 4, low bits ignored", 12'h813);

    eng_idle = 1'b0;
    read_and_check("R3 busy read denied", 12'h804);
    read_and_check("R5 pointer read while busy", 12'h040);
    eng_idle = 1'b1; eng_enable = 1'b1;
    read_and_check("R3 enabled read denied", 12'h808);
    eng_enable = 1'b0;
    read_and_check("R3 error lasts one transfer", 12'h808);

    read_and_check("R4 index DEPTH reads zero", 12'(12'h800 + DEPTH * 4));
    read_and_check("R4 top of window reads zero", 12'hFFC);
    read_and_check("R8 unmapped offset", 12'h044);

    apb_write(12'h040, d, e);
    chk("R8 write returns zero", d, '0);
    chk("R8 write no error", {31'd0, e}, '0);
    apb_write(12'h800, d, e);
    read_and_check("R8 write left pointers", 12'h040);
    read_and_check("R8 write left entry 0", 12'h800);

    apb_read(12'h040, p0, e);
    for (int i = 0; i < DEPTH; i++) begin
      eng_idle = i[0];
      apb_read(12'(12'h800 + i * 4), d, e);
    end
    eng_idle = 1'b1;
    apb_read(12'h040, d, e);
    chk("R7 window reads keep pointers", d, p0);

    do_drain();
    do_drain();
    for (int i = 0; i < 14; i++) do_fill(32'hB000_0000 + i);
    read_and_check("R6 wrap of write pointer", 12'h040);
    read_and_check("R2 R6 entry after wrap", 12'(12'h800 + 2 * 4));

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0, 1: do_fill($urandom);
        2: do_drain();
        3: begin
          eng_idle   = ($urandom % 3) != 0;
          eng_enable = ($urandom % 4) == 0;
          read_and_check("R2 R3 R4 random window read",
                         12'(12'h800 + ($urandom % (DEPTH + 4)) * 4 + ($urandom % 4)));
          eng_idle = 1'b1; eng_enable = 1'b0;
        end
        default: read_and_check("R5 random pointer read", 12'h040);
      endcase
    end

    for (int i = 0; i < DEPTH; i++)
      read_and_check("R2 final sweep", 12'(12'h800 + i * 4));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule